// File: doc/BRIEF.md
# Timeslot DMA Request Scheduler

This block paces DMA handshakes for a time-division serial interface. A frame is cut into 2 Mb/s timeslots, and every timeslot owns four consecutive 8-bit local channels: slot `s` holds channels `4s` to `4s+3`, 128 channels in all. A table of 128 enable bits marks the channels to be moved. One bit covers both directions of its channel. For each timeslot that has at least one marked channel, the block lowers an active-low request, waits for the acknowledge, and then steps through one burst with one beat per marked channel. It shows the index of each channel on an output.

Reads out of the device use request and acknowledge pair 1 (`rd_*`). They start when a timeslot begins. Writes into the device use pair 0 (`wr_*`). They start when a timeslot ends. The global enable is sampled only on the frame strobe, so transfers always begin on a frame boundary. In the first frame after the block is enabled, timeslot 0 is left out for setup. If a request is still outstanding when the next strobe of its own direction arrives, the request is abandoned and a sticky overrun flag is set.

The timing source asserts `frame_sync` together with the `slot_begin` of timeslot 0. `slot_begin` and `slot_end` are single-cycle strobes. Each direction is handled by a state machine with three states:
- ENG_IDLE: request high.
- ENG_WAIT: request low, no beat taken yet.
- ENG_BURST: request low, at least one beat done.

Its transitions are:
- LAUNCH (ENG_IDLE to ENG_WAIT): a strobe arrives while the slot has enabled channels.
- FIRST_BEAT (ENG_WAIT to ENG_BURST): the acknowledge arrives and channels remain.
- NEXT_BEAT (ENG_BURST to ENG_BURST): the acknowledge arrives and channels remain.
- DONE (ENG_WAIT or ENG_BURST to ENG_IDLE): the acknowledge consumes the last channel.
- DROP (ENG_WAIT or ENG_BURST to ENG_IDLE): a strobe arrives and the new slot has no enabled channels.
- RELAUNCH (ENG_WAIT or ENG_BURST to ENG_WAIT): a strobe arrives and the new slot has enabled channels.

Top module: `tsdma_sched`

## Requirements
- R1: Timeslot `s` owns channels `4s..4s+3`, and enable bit `chan_en[c]` marks channel `c`. A slot whose four bits are all zero raises no request. The same bits select the channels for both the read and the write burst.
- R2: `dma_enable` is sampled only in a cycle where `frame_sync` is high. A change in the middle of a frame has no effect on requests until the next frame strobe.
- R3: A read burst for the slot that a `slot_begin` opens drives `rd_req_n` low in the cycle after that strobe.
- R4: A write burst for the current slot drives `wr_req_n` low in the cycle after `slot_end`.
- R5: In the first frame after the enable takes effect, timeslot 0 raises no read or write request. From the second frame on, timeslot 0 is served like any other slot.
- R6: Each cycle with the request low and the acknowledge high moves one channel. The channel index output shows the enabled channels in ascending order. The request returns high in the cycle after the beat of the last channel.
- R7: `*_burst_len` equals the number of enabled channels in the burst (1 to 4) while the request is low, and 0 while it is high.
- R8: If a request is still low when the next strobe of its own direction arrives, the rest of its burst is dropped and the sticky `*_overrun` flag goes high. A burst for the new slot is launched in the same cycle if that slot has enabled channels.
- R9: After reset both requests are high, both burst lengths are 0 and both overrun flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | Frame strobe, coincides with slot_begin of timeslot 0 |
| slot_begin | input | 1 | Timeslot start strobe |
| slot_end | input | 1 | Timeslot end strobe |
| dma_enable | input | 1 | Global enable, applied at the next frame strobe |
| chan_en | input | 128 | Per-channel DMA enable bits |
| rd_ack | input | 1 | Read acknowledge, one beat per high cycle |
| wr_ack | input | 1 | Write acknowledge, one beat per high cycle |
| rd_req_n | output | 1 | Read request, active low |
| wr_req_n | output | 1 | Write request, active low |
| rd_chan | output | 7 | Channel index of the current read beat |
| wr_chan | output | 7 | Channel index of the current write beat |
| rd_burst_len | output | 3 | Channel count of the active read burst |
| wr_burst_len | output | 3 | Channel count of the active write burst |
| rd_overrun | output | 1 | Sticky read overrun flag |
| wr_overrun | output | 1 | Sticky write overrun flag |

## Verification
Slots are driven with single, sparse, full and empty four-bit masks. Single and full masks separate a correct burst length from an off-by-one beat count. Sparse masks such as 1010 and 0110 show whether the channel order skips disabled lanes and ascends. The enable is changed in the middle of a frame in both directions, and timeslot 0 is enabled over two frames, so deferral and the first-frame rule can each be seen on their own. Acknowledges are then withheld across a second strobe to force the drop-and-relaunch path in each direction.

// File: rtl/tsdma_pkg.sv
package tsdma_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_WAIT  = 2'd1,
        ENG_BURST = 2'd2
    } eng_state_t;
endpackage

// File: rtl/tsdma_slot_timer.sv
module tsdma_slot_timer #(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              slot_begin,
    input  logic              dma_enable,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SLOT_W-1:0] slot_next,
    output logic              live_q,
    output logic              live_next,
    output logic              setup_q,
    output logic              setup_next
);
    // the opening slot, with wrap at the last slot of a frame
    always_comb begin
        if (frame_sync)
            slot_next = '0;
        else if (slot_q == SLOT_W'(NUM_SLOTS - 1))
            slot_next = '0;
        else
            slot_next = slot_q + 1'b1;
        live_next  = frame_sync ? dma_enable : live_q;
        setup_next = frame_sync ? (dma_enable & ~live_q) : setup_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= '0;
            live_q  <= 1'b0;
            setup_q <= 1'b0;
        end else begin
            if (slot_begin) slot_q <= slot_next;
            live_q  <= live_next;
            setup_q <= setup_next;
        end
    end
endmodule

// File: rtl/tsdma_engine.sv
module tsdma_engine
    import tsdma_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int LANES  = 4,
    localparam int IDX_W = $clog2(LANES),
    localparam int LEN_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe,
    input  logic                    launch,
    input  logic [SLOT_W-1:0]       slot_in,
    input  logic [LANES-1:0]        mask_in,
    input  logic                    ack,
    output logic                    req_n,
    output logic [SLOT_W+IDX_W-1:0] chan,
    output logic [LEN_W-1:0]        burst_len,
    output logic                    overrun
);
    eng_state_t        state_q, state_d;
    logic [LANES-1:0]  mask_q, mask_d, low_bit;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [LEN_W-1:0]  len_q, len_d, len_in;
    logic              ovr_q, ovr_d;
    logic [IDX_W-1:0]  low_idx;

    always_comb begin
        len_in = '0;
        for (int i = 0; i < LANES; i++)
            len_in = len_in + LEN_W'(mask_in[i]);
        low_idx = '0;
        for (int i = LANES - 1; i >= 0; i--)
            if (mask_q[i]) low_idx = IDX_W'(i);
        low_bit = mask_q & (~mask_q + 1'b1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        slot_d  = slot_q;
        len_d   = len_q;
        ovr_d   = ovr_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (launch) begin
                    state_d = ENG_WAIT;
                    mask_d  = mask_in;
                    slot_d  = slot_in;
                    len_d   = len_in;
                end
            end
            ENG_WAIT, ENG_BURST: begin
                if (strobe) begin
                    ovr_d = 1'b1;
                    if (launch) begin
                        state_d = ENG_WAIT;
                        mask_d  = mask_in;
                        slot_d  = slot_in;
                        len_d   = len_in;
                    end else begin
                        state_d = ENG_IDLE;
                        mask_d  = '0;
                    end
                end else if (ack) begin
                    mask_d  = mask_q & ~low_bit;
                    state_d = (mask_d == '0) ? ENG_IDLE : ENG_BURST;
                end
            end
            default: state_d = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            mask_q  <= '0;
            slot_q  <= '0;
            len_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            slot_q  <= slot_d;
            len_q   <= len_d;
            ovr_q   <= ovr_d;
        end
    end

    // outputs
    always_comb begin
        req_n     = (state_q == ENG_IDLE);
        burst_len = (state_q == ENG_IDLE) ? '0 : len_q;
        chan      = {slot_q, low_idx};
        overrun   = ovr_q;
    end
endmodule

// File: rtl/tsdma_sched.sv
module tsdma_sched #(
    parameter int NUM_CH = 128,
    parameter int LANES  = 4,
    localparam int NUM_SLOTS = NUM_CH / LANES,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int IDX_W  = $clog2(LANES),
    localparam int CH_W   = SLOT_W + IDX_W,
    localparam int LEN_W  = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              slot_begin,
    input  logic              slot_end,
    input  logic              dma_enable,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic              rd_ack,
    input  logic              wr_ack,
    output logic              rd_req_n,
    output logic              wr_req_n,
    output logic [CH_W-1:0]   rd_chan,
    output logic [CH_W-1:0]   wr_chan,
    output logic [LEN_W-1:0]  rd_burst_len,
    output logic [LEN_W-1:0]  wr_burst_len,
    output logic              rd_overrun,
    output logic              wr_overrun
);
    logic [SLOT_W-1:0] slot_q, slot_next;
    logic              live_q, live_next, setup_q, setup_next;
    logic [LANES-1:0]  rd_mask, wr_mask;
    logic              rd_launch, wr_launch;

    tsdma_slot_timer #(.NUM_SLOTS(NUM_SLOTS)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .slot_begin(slot_begin), .dma_enable(dma_enable),
        .slot_q(slot_q), .slot_next(slot_next),
        .live_q(live_q), .live_next(live_next),
        .setup_q(setup_q), .setup_next(setup_next)
    );

    // reads serve the slot being opened, writes the slot being closed
    always_comb begin
        rd_mask   = chan_en[int'(slot_next) * LANES +: LANES];
        wr_mask   = chan_en[int'(slot_q) * LANES +: LANES];
        rd_launch = slot_begin & live_next & (|rd_mask)
                  & ~(setup_next & (slot_next == '0));
        wr_launch = slot_end & live_q & (|wr_mask)
                  & ~(setup_q & (slot_q == '0));
    end

    tsdma_engine #(.SLOT_W(SLOT_W), .LANES(LANES)) u_rd (
        .clk(clk), .rst_n(rst_n), .strobe(slot_begin), .launch(rd_launch),
        .slot_in(slot_next), .mask_in(rd_mask), .ack(rd_ack),
        .req_n(rd_req_n), .chan(rd_chan), .burst_len(rd_burst_len),
        .overrun(rd_overrun)
    );

    tsdma_engine #(.SLOT_W(SLOT_W), .LANES(LANES)) u_wr (
        .clk(clk), .rst_n(rst_n), .strobe(slot_end), .launch(wr_launch),
        .slot_in(slot_q), .mask_in(wr_mask), .ack(wr_ack),
        .req_n(wr_req_n), .chan(wr_chan), .burst_len(wr_burst_len),
        .overrun(wr_overrun)
    );
endmodule

// File: rtl/tsdma_sched_chk.sv
module tsdma_sched_chk #(
    parameter int CH_W  = 7,
    parameter int LEN_W = 3,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_begin,
    input logic             slot_end,
    input logic             rd_ack,
    input logic             wr_ack,
    input logic             rd_req_n,
    input logic             wr_req_n,
    input logic [CH_W-1:0]  rd_chan,
    input logic [CH_W-1:0]  wr_chan,
    input logic [LEN_W-1:0] rd_burst_len,
    input logic [LEN_W-1:0] wr_burst_len,
    input logic             rd_overrun,
    input logic             wr_overrun
);
    p_rd_on_begin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_req_n) |-> $past(slot_begin));
    p_wr_on_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_req_n) |-> $past(slot_end));
    p_rd_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_n |-> (rd_burst_len != '0 && int'(rd_burst_len) <= LANES));
    p_wr_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req_n |-> (wr_burst_len != '0 && int'(wr_burst_len) <= LANES));
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req_n && !rd_ack && !slot_begin) |=> (!rd_req_n && $stable(rd_chan)));
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req_n && !wr_ack && !slot_end) |=> (!wr_req_n && $stable(wr_chan)));
    p_rd_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_overrun |=> rd_overrun);
    p_rd_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_overrun) |-> ($past(slot_begin) && !$past(rd_req_n)));
    p_wr_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_overrun) |-> ($past(slot_end) && !$past(wr_req_n)));
endmodule

bind tsdma_sched tsdma_sched_chk #(.CH_W(CH_W), .LEN_W(LEN_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_begin(slot_begin), .slot_end(slot_end),
    .rd_ack(rd_ack), .wr_ack(wr_ack), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
    .rd_chan(rd_chan), .wr_chan(wr_chan), .rd_burst_len(rd_burst_len),
    .wr_burst_len(wr_burst_len), .rd_overrun(rd_overrun), .wr_overrun(wr_overrun)
);

// File: tb/tsdma_sched_bench.sv
module tsdma_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {mask[3:0], count[3:0]} for slots 1..6
    localparam logic [7:0] VEC [NV] = '{8'h11, 8'hA2, 8'hF4, 8'h00, 8'h81, 8'h62};

    logic clk = 0, rst_n = 0;
    logic frame_sync = 0, slot_begin = 0, slot_end = 0, dma_enable = 0;
    logic [127:0] chan_en = '0;
    logic rd_ack = 0, wr_ack = 0;
    logic rd_req_n, wr_req_n, rd_overrun, wr_overrun;
    logic [6:0] rd_chan, wr_chan;
    logic [2:0] rd_burst_len, wr_burst_len;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsdma_sched u_tsdma_sched (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_begin(slot_begin),
        .slot_end(slot_end), .dma_enable(dma_enable), .chan_en(chan_en),
        .rd_ack(rd_ack), .wr_ack(wr_ack), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
        .rd_chan(rd_chan), .wr_chan(wr_chan), .rd_burst_len(rd_burst_len),
        .wr_burst_len(wr_burst_len), .rd_overrun(rd_overrun), .wr_overrun(wr_overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input bit fs, input bit sb, input bit se);
        @(negedge clk);
        frame_sync = fs; slot_begin = sb; slot_end = se;
        @(negedge clk);
        frame_sync = 0; slot_begin = 0; slot_end = 0;
    endtask

    // serve a burst, checking ascending channel order and release (R6)
    task automatic serve(input bit wr, input int slot, input logic [3:0] mask);
        for (int b = 0; b < 4; b++) begin
            if (mask[b]) begin
                chk((wr ? wr_chan : rd_chan) == 7'(slot*4+b), "R6 chan",
                    int'(wr ? wr_chan : rd_chan), slot*4+b);
                if (wr) wr_ack = 1; else rd_ack = 1;
                @(negedge clk);
            end
        end
        rd_ack = 0; wr_ack = 0;
        chk((wr ? wr_req_n : rd_req_n) == 1'b1, "R6 release", int'(wr ? wr_req_n : rd_req_n), 1);
    endtask

    task automatic expect_burst(input bit wr, input int cnt, input string req);
        chk((wr ? wr_req_n : rd_req_n) == (cnt == 0), req, int'(wr ? wr_req_n : rd_req_n), int'(cnt == 0));
        chk(int'(wr ? wr_burst_len : rd_burst_len) == cnt, "R7 len", int'(wr ? wr_burst_len : rd_burst_len), cnt);
    endtask

    logic done = 0;
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        chan_en[3:0] = 4'b0100;
        for (int i = 0; i < NV; i++) chan_en[(i+1)*4 +: 4] = VEC[i][7:4];
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(rd_req_n && wr_req_n, "R9 req", int'({rd_req_n, wr_req_n}), 3);
        chk(rd_burst_len == 0 && wr_burst_len == 0, "R9 len", int'(rd_burst_len), 0);
        chk(!rd_overrun && !wr_overrun, "R9 ovr", int'(rd_overrun), 0);
        rst_n = 1;
        @(negedge clk);
        // R2: enable mid-frame has no effect yet
        dma_enable = 1;
        strobe(0, 1, 0);
        chk(rd_req_n, "R2 deferred rd", int'(rd_req_n), 1);
        strobe(0, 0, 1);
        chk(wr_req_n, "R2 deferred wr", int'(wr_req_n), 1);
        // R5: first frame, slot 0 suppressed
        strobe(1, 1, 0);
        chk(rd_req_n, "R5 slot0 rd first frame", int'(rd_req_n), 1);
        strobe(0, 0, 1);
        chk(wr_req_n, "R5 slot0 wr first frame", int'(wr_req_n), 1);
        // table walk over slots 1..6 (R1, R3, R4, R6, R7)
        for (int i = 0; i < NV; i++) begin
            strobe(0, 1, 0);
            expect_burst(0, int'(VEC[i][3:0]), "R3 rd req");
            if (VEC[i][7:4] != 0) serve(0, i+1, VEC[i][7:4]);
            strobe(0, 0, 1);
            expect_burst(1, int'(VEC[i][3:0]), "R4 wr req");
            if (VEC[i][7:4] != 0) serve(1, i+1, VEC[i][7:4]);
            else chk(wr_req_n && rd_req_n, "R1 empty slot", int'(wr_req_n), 1);
        end
        // R5: second frame serves slot 0
        strobe(1, 1, 0);
        expect_burst(0, 1, "R5 slot0 rd second frame");
        serve(0, 0, 4'b0100);
        strobe(0, 0, 1);
        expect_burst(1, 1, "R5 slot0 wr second frame");
        serve(1, 0, 4'b0100);
        // R8: read overrun, slot 1 unacked then slot 2 opens
        strobe(0, 1, 0);
        chk(!rd_req_n && !rd_overrun, "R8 pre rd", int'(rd_overrun), 0);
        strobe(0, 1, 0);
        chk(rd_overrun, "R8 rd overrun", int'(rd_overrun), 1);
        expect_burst(0, 2, "R8 rd relaunch");
        serve(0, 2, 4'b1010);
        // R8: write overrun on slot 2
        strobe(0, 0, 1);
        chk(!wr_overrun, "R8 pre wr", int'(wr_overrun), 0);
        strobe(0, 0, 1);
        chk(wr_overrun, "R8 wr overrun", int'(wr_overrun), 1);
        expect_burst(1, 2, "R8 wr relaunch");
        serve(1, 2, 4'b1010);
        chk(rd_overrun, "R8 rd sticky", int'(rd_overrun), 1);
        // R2: disable mid-frame still serves the rest of the frame
        dma_enable = 0;
        strobe(0, 1, 0);
        expect_burst(0, 4, "R2 still live");
        serve(0, 3, 4'b1111);
        strobe(1, 1, 0);
        chk(rd_req_n, "R2 off after frame", int'(rd_req_n), 1);
        strobe(0, 0, 1);
        chk(wr_req_n, "R2 wr off after frame", int'(wr_req_n), 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule